// File: doc/BRIEF.md
# Lattice Grid Raster Writer

This block draws a square lattice-gas simulation grid into a frame-buffer memory. It is the master side of a simple write bus: it raises a write request together with a pixel coordinate and a colour, and holds all three until the memory returns a one-cycle acknowledge. After reset it first paints every pixel of the screen black. After that it scans the simulation grid again and again, without end.

Each grid node is drawn as a solid square of SCALE x SCALE pixels, and the whole grid is centred on the screen. The block reads one node at a time through a small lookup port. It presents a node column and row, and the grid storage returns that node's 7-bit word in the same cycle. The colour depends only on that word. Empty nodes are black. Occupied nodes get a brightness that rises with the number of particles. Wall nodes get a fixed colour of their own. With the default sizes (640x480 screen, 45x45 nodes, scale 8) the grid covers 360x360 pixels, with its top-left corner at x = 140, y = 60.

Top module: `lattice_raster_writer`

## Requirements
- R1: While rst_n is low at a rising edge, the following outputs are zero from that edge on: wr_req, pix_x, pix_y and pix_data.
- R2: After reset, the first SCREEN_W*SCREEN_H accepted writes cover the whole screen in raster order (x increments fastest, starting at 0,0) with pix_data 0. No grid pixel is written before this clear finishes.
- R3: Once wr_req is high, it stays high with pix_x, pix_y and pix_data unchanged until a cycle in which wr_ack is high. wr_req is low in the cycle after that acknowledge.
- R4: After each accepted write, wr_req is low for exactly one cycle before the next request.
- R5: After the clear, accepted writes scan the grid region in raster order. The region has width and height GRID_N*SCALE, and its origin is at ((SCREEN_W-GRID_N*SCALE)/2, (SCREEN_H-GRID_N*SCALE)/2). The pixel at region offset (u,v) shows node column u/SCALE and node row v/SCALE.
- R6: After the bottom-right pixel of the region, the scan starts again at the top-left pixel of the region. No second clear happens.
- R7: The colour of a grid pixel comes from the node_word presented for node_col/node_row in the cycle just before its request is raised.
- R8: A non-wall node word holds one particle flag per direction in bits [6:3]. It is drawn with colour k*LEVEL_STEP, where k is the number of flags set. For an empty node this is 0.
- R9: A node word whose bits [2:0] equal 3'b111 is a wall. It is drawn with WALL_COLOR, whatever its particle flags are. Any other value of bits [2:0] does not make the node a wall.
- R10: While the grid is being drawn, no request addresses a pixel outside the grid region.
- R11: A reset applied in the middle of drawing restarts the sequence with a full black clear from pixel (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_col | output | $clog2(GRID_N) (6) | Column of the node being looked up |
| node_row | output | $clog2(GRID_N) (6) | Row of the node being looked up |
| node_word | input | 7 | Word of the addressed node: [6:3] particle flags, [2:0] tag |
| wr_req | output | 1 | Write request to the frame buffer |
| pix_x | output | $clog2(SCREEN_W) (10) | Pixel column of the write |
| pix_y | output | $clog2(SCREEN_H) (9) | Pixel row of the write |
| pix_data | output | PIX_W (8) | Pixel colour of the write |
| wr_ack | input | 1 | One-cycle acknowledge that accepts the pending write |

## Verification
On every cycle the assertions check the bus discipline:
- the request, coordinate and colour are held until an acknowledge;
- the request drops after the acknowledge;
- there is exactly one idle cycle between writes;
- reset forces the outputs to zero;
- clear writes are black;
- grid writes stay inside the centred region;
- a frame wraps at the region's bottom-right corner.

Only the bench scenarios can show the content of the sequence. These cover:
- the exact raster order of the clear and of the grid scan;
- the node-to-colour mapping for particle counts, wall tags and near-wall tags;
- the pickup of grid changes between frames;
- the restart after a reset in the middle of a frame.

// File: rtl/lrw_pkg.sv
// Shared definitions for the lattice raster writer: FSM state encoding
// and the layout of a node word.
package lrw_pkg;

    // State numbers kept as behaviour: 2 = clear write, 1 = wait ack, 0 = grid write
    typedef enum logic [1:0] {
        ST_DRAW = 2'd0,
        ST_WAIT = 2'd1,
        ST_FILL = 2'd2
    } lrw_state_t;

    localparam int NODE_W = 7;   // node word width
    localparam int TAG_W  = 3;   // tag field in the low bits
    localparam int DIR_N  = 4;   // one particle flag per direction above the tag
    localparam logic [TAG_W-1:0] TAG_WALL = 3'b111;

endpackage

// File: rtl/lrw_wrap_counter.sv
// Modulo counter: steps when 'step' is high and wraps from LIMIT-1 to 0.
// Assumes LIMIT >= 1 and WIDTH large enough to hold LIMIT-1.
module lrw_wrap_counter #(
    parameter int LIMIT = 8,
    parameter int WIDTH = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] value,
    output logic             at_last
);

    // Flags the final count so callers can chain carries
    assign at_last = (value == WIDTH'(LIMIT - 1));

    // Count register with synchronous reset and wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (step) begin
            value <= at_last ? '0 : value + 1'b1;
        end
    end

endmodule

// File: rtl/lrw_node_shader.sv
// Maps a node word to a pixel colour. A wall tag wins over everything else.
// Otherwise the colour is the particle-flag count times LEVEL_STEP.
// Assumes DIR_N*LEVEL_STEP fits in PIX_W bits.
module lrw_node_shader
    import lrw_pkg::*;
#(
    parameter int               PIX_W      = 8,
    parameter int               LEVEL_STEP = 63,
    parameter logic [PIX_W-1:0] WALL_COLOR = 8'hE0
) (
    input  logic [NODE_W-1:0] node_word,
    output logic [PIX_W-1:0]  colour
);

    localparam int CNT_W = $clog2(DIR_N + 1);

    logic [CNT_W-1:0] flags;

    // Counts the particle flags and picks the wall or brightness colour
    always_comb begin
        flags = '0;
        for (int i = 0; i < DIR_N; i++) begin
            flags = flags + CNT_W'(node_word[TAG_W + i]);
        end
        if (node_word[TAG_W-1:0] == TAG_WALL) begin
            colour = WALL_COLOR;
        end else begin
            colour = PIX_W'(int'(flags) * LEVEL_STEP);
        end
    end

endmodule

// File: rtl/lattice_raster_writer.sv
// Frame-buffer write master for a square lattice-gas grid.
// After reset it clears the full screen to black. It then scans the
// grid region without end, drawing each node as a SCALE x SCALE block
// centred on the screen. Every write is held until a one-cycle
// acknowledge. Assumes GRID_N >= 2 and GRID_N*SCALE <= both screen sizes.
// node_word must be valid in the same cycle that node_col/node_row are presented.
module lattice_raster_writer
    import lrw_pkg::*;
#(
    parameter int               SCREEN_W   = 640,
    parameter int               SCREEN_H   = 480,
    parameter int               GRID_N     = 45,
    parameter int               SCALE      = 8,
    parameter int               PIX_W      = 8,
    parameter int               LEVEL_STEP = 63,
    parameter logic [PIX_W-1:0] WALL_COLOR = 8'hE0,
    localparam int              XW         = $clog2(SCREEN_W),
    localparam int              YW         = $clog2(SCREEN_H),
    localparam int              GW         = $clog2(GRID_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [GW-1:0]     node_col,
    output logic [GW-1:0]     node_row,
    input  logic [NODE_W-1:0] node_word,
    output logic              wr_req,
    output logic [XW-1:0]     pix_x,
    output logic [YW-1:0]     pix_y,
    output logic [PIX_W-1:0]  pix_data,
    input  logic              wr_ack
);

    localparam int SPAN  = GRID_N * SCALE;
    localparam int X_OFF = (SCREEN_W - SPAN) / 2;
    localparam int Y_OFF = (SCREEN_H - SPAN) / 2;
    localparam int MAXL  = (SCALE > GRID_N) ? SCALE : GRID_N;
    localparam int CW    = $clog2(MAXL + 1);
    localparam int LVLS  = 4;   // sub-x, node col, sub-y, node row

    lrw_state_t       state;
    logic             fill_q;
    logic             clr_adv;
    logic             drw_adv;
    logic [XW-1:0]    cx;
    logic [YW-1:0]    cy;
    logic             cx_last;
    logic             cy_last;
    logic [LVLS-1:0]  g_step;
    logic [LVLS-1:0]  g_last;
    logic [CW-1:0]    g_val [LVLS];
    logic             frame_wrap;
    logic [PIX_W-1:0] shade;
    logic [XW-1:0]    draw_x;
    logic [YW-1:0]    draw_y;

    // Accept events: one per acknowledged write, split by phase
    assign clr_adv = (state == ST_WAIT) && wr_ack && fill_q;
    assign drw_adv = (state == ST_WAIT) && wr_ack && !fill_q;

    // Full-screen clear scan, x fastest
    lrw_wrap_counter #(.LIMIT(SCREEN_W), .WIDTH(XW)) u_clr_x (
        .clk(clk), .rst_n(rst_n), .step(clr_adv),
        .value(cx), .at_last(cx_last)
    );
    lrw_wrap_counter #(.LIMIT(SCREEN_H), .WIDTH(YW)) u_clr_y (
        .clk(clk), .rst_n(rst_n), .step(clr_adv && cx_last),
        .value(cy), .at_last(cy_last)
    );

    // Grid scan as a carry chain: sub-x, node column, sub-y, node row
    assign g_step[0] = drw_adv;
    for (genvar i = 0; i < LVLS; i++) begin : g_chain
        localparam int LIM = (i % 2 == 0) ? SCALE : GRID_N;
        lrw_wrap_counter #(.LIMIT(LIM), .WIDTH(CW)) u_lvl (
            .clk(clk), .rst_n(rst_n), .step(g_step[i]),
            .value(g_val[i]), .at_last(g_last[i])
        );
        if (i < LVLS - 1) begin : g_carry
            assign g_step[i+1] = g_step[i] && g_last[i];
        end
    end
    assign frame_wrap = g_step[LVLS-1] && g_last[LVLS-1];

    // Node lookup follows the grid scan position
    assign node_col = GW'(g_val[1]);
    assign node_row = GW'(g_val[3]);

    lrw_node_shader #(
        .PIX_W(PIX_W), .LEVEL_STEP(LEVEL_STEP), .WALL_COLOR(WALL_COLOR)
    ) u_shader (
        .node_word(node_word),
        .colour(shade)
    );

    // Screen coordinate of the current grid-scan pixel
    always_comb begin
        draw_x = XW'(X_OFF + int'(g_val[1]) * SCALE + int'(g_val[0]));
        draw_y = YW'(Y_OFF + int'(g_val[3]) * SCALE + int'(g_val[2]));
    end

    // Phase flag: set by reset, cleared when the last clear pixel is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= 1'b1;
        end else if (clr_adv && cx_last && cy_last) begin
            fill_q <= 1'b0;
        end
    end

    // Bus master FSM: issue a write, hold it until acknowledge, then pick the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            wr_req   <= 1'b0;
            pix_x    <= '0;
            pix_y    <= '0;
            pix_data <= '0;
        end else begin
            case (state)
                ST_FILL: begin
                    pix_x    <= cx;
                    pix_y    <= cy;
                    pix_data <= '0;
                    wr_req   <= 1'b1;
                    state    <= ST_WAIT;
                end
                ST_DRAW: begin
                    pix_x    <= draw_x;
                    pix_y    <= draw_y;
                    pix_data <= shade;
                    wr_req   <= 1'b1;
                    state    <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (wr_ack) begin
                        wr_req <= 1'b0;
                        state  <= (fill_q && !(cx_last && cy_last)) ? ST_FILL : ST_DRAW;
                    end
                end
                default: begin
                    wr_req <= 1'b0;
                    state  <= ST_FILL;
                end
            endcase
        end
    end

endmodule

// File: rtl/lrw_checker.sv
// Protocol and placement properties for lattice_raster_writer, attached by bind.
module lrw_checker #(
    parameter int SCREEN_W = 640,
    parameter int SCREEN_H = 480,
    parameter int GRID_N   = 45,
    parameter int SCALE    = 8,
    parameter int PIX_W    = 8,
    parameter int XW       = 10,
    parameter int YW       = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_req,
    input logic             wr_ack,
    input logic [XW-1:0]    pix_x,
    input logic [YW-1:0]    pix_y,
    input logic [PIX_W-1:0] pix_data,
    input logic             fill,
    input logic             frame_wrap
);

    localparam int SPAN  = GRID_N * SCALE;
    localparam int X_OFF = (SCREEN_W - SPAN) / 2;
    localparam int Y_OFF = (SCREEN_H - SPAN) / 2;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!wr_req && pix_x == '0 && pix_y == '0 && pix_data == '0)); // R1

    AST_CLEAR_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && fill) |-> (pix_data == '0)); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(pix_x) && $stable(pix_y) && $stable(pix_data))); // R3

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> !wr_req); // R3

    AST_ONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_req) |=> wr_req); // R4

    AST_FRAME_WRAP_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && frame_wrap) |->
            (int'(pix_x) == X_OFF + SPAN - 1 && int'(pix_y) == Y_OFF + SPAN - 1)); // R6

    AST_DRAW_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !fill) |->
            (int'(pix_x) >= X_OFF && int'(pix_x) < X_OFF + SPAN &&
             int'(pix_y) >= Y_OFF && int'(pix_y) < Y_OFF + SPAN)); // R10

endmodule

bind lattice_raster_writer lrw_checker #(
    .SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H), .GRID_N(GRID_N),
    .SCALE(SCALE), .PIX_W(PIX_W), .XW(XW), .YW(YW)
) i_lrw_checker (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ack(wr_ack),
    .pix_x(pix_x), .pix_y(pix_y), .pix_data(pix_data),
    .fill(fill_q), .frame_wrap(frame_wrap)
);

// File: tb/test_lattice_raster_writer.sv
// Bench: acknowledging memory model plus a behavioural model of the expected
// write sequence, compared on every clock.
module test_lattice_raster_writer;

    localparam int SW   = 40;
    localparam int SH   = 30;
    localparam int GN   = 4;
    localparam int SC   = 4;
    localparam int SPAN = GN * SC;
    localparam int XO   = (SW - SPAN) / 2;
    localparam int YO   = (SH - SPAN) / 2;
    localparam int AREA = SPAN * SPAN;
    localparam int CLR  = SW * SH;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_ack = 1'b0;
    logic [1:0] node_col, node_row;
    logic [6:0] node_word;
    logic       wr_req;
    logic [5:0] pix_x;
    logic [4:0] pix_y;
    logic [7:0] pix_data;

    logic [6:0] grid [GN][GN];

    int   vectors = 0, errors = 0;
    int   idx = 0, frame_no = 0, npos = 0, nrst = 0;
    int   delay = 0, wcnt = 0, cycles = 0, seed = 12345;
    bit   rand_delay = 0, mid_reset = 0;
    logic prev_wr = 0, prev_ack = 0;
    logic [5:0] prev_x = '0;
    logic [4:0] prev_y = '0;
    logic [7:0] prev_d = '0;

    assign node_word = grid[node_row][node_col];

    lattice_raster_writer #(
        .SCREEN_W(SW), .SCREEN_H(SH), .GRID_N(GN), .SCALE(SC)
    ) i_lattice_raster_writer (
        .clk(clk), .rst_n(rst_n), .node_col(node_col), .node_row(node_row),
        .node_word(node_word), .wr_req(wr_req), .pix_x(pix_x), .pix_y(pix_y),
        .pix_data(pix_data), .wr_ack(wr_ack)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_colour(input logic [6:0] w);
        int n = 0;
        if (w[2:0] == 3'b111) return 8'hE0;
        for (int i = 3; i < 7; i++) n += int'(w[i]);
        return 8'(n * 63);
    endfunction

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    // Loads the grid pattern and ack delay used for frame f
    task automatic set_grid(input int f);
        for (int r = 0; r < GN; r++) begin
            for (int c = 0; c < GN; c++) begin
                logic [3:0] m;
                int k;
                m = '0;
                k = (r * GN + c) % 5;
                case (f)
                    0: grid[r][c] = '0;
                    1: begin
                        for (int j = 0; j < k; j++) m[(j + c) % 4] = 1'b1;
                        grid[r][c] = {m, (r == 3 && c == 3) ? 3'b111 : 3'(r)};
                    end
                    2: grid[r][c] = {4'(r * 4 + c), ((r + c) % 2 == 0) ? 3'b111 : 3'b110};
                    default: grid[r][c] = 7'(next_rand());
                endcase
            end
        end
        case (f)
            0: begin delay = 0; rand_delay = 0; end
            1: begin delay = 1; rand_delay = 0; end
            2: begin delay = 3; rand_delay = 0; end
            default: rand_delay = 1;
        endcase
    endtask

    // Edge bookkeeping for the reset-state and protocol checks
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            npos = 0;
            nrst++;
        end else begin
            npos++;
            nrst = 0;
        end
    end

    // Compares one accepted write against the expected sequence
    task automatic compare_write();
        int ex, ey, p;
        logic [7:0] ec;
        string tp, tc;
        if (idx < CLR) begin
            ex = idx % SW;
            ey = idx / SW;
            ec = 8'h00;
            tp = mid_reset ? "R2 R11" : "R2";
            tc = tp;
        end else begin
            p  = (idx - CLR) % AREA;
            ex = XO + p % SPAN;
            ey = YO + p / SPAN;
            ec = ref_colour(grid[(p / SPAN) / SC][(p % SPAN) / SC]);
            tp = "R5 R6 R10";
            tc = (grid[(p / SPAN) / SC][(p % SPAN) / SC][2:0] == 3'b111) ? "R7 R9" : "R7 R8";
        end
        chk(int'(pix_x) == ex, tp, "pixel x", int'(pix_x), ex);
        chk(int'(pix_y) == ey, tp, "pixel y", int'(pix_y), ey);
        chk(int'(pix_data) == int'(ec), tc, "pixel colour", int'(pix_data), int'(ec));
        if (idx >= CLR && (idx - CLR) % AREA == AREA - 1) begin
            frame_no++;
            set_grid(frame_no);
        end
        idx++;
    endtask

    // Per-clock protocol checks and acknowledging memory model
    always @(negedge clk) begin
        if (!rst_n) begin
            if (nrst >= 1) begin
                chk(wr_req == 1'b0, "R1", "wr_req in reset", int'(wr_req), 0);
                chk(pix_x == '0 && pix_y == '0 && pix_data == '0, "R1",
                    "coord/data in reset", int'(pix_x) + int'(pix_y) + int'(pix_data), 0);
            end
            idx = 0; wr_ack = 1'b0; wcnt = 0; prev_wr = 1'b0; prev_ack = 1'b0;
        end else begin
            if (npos >= 1) begin
                if (prev_wr && prev_ack) begin
                    chk(!wr_req, "R3", "request after ack", int'(wr_req), 0);
                end else if (prev_wr) begin
                    chk(wr_req && pix_x == prev_x && pix_y == prev_y && pix_data == prev_d,
                        "R3", "request held", int'(wr_req), 1);
                end else begin
                    chk(wr_req, "R4", "request after idle cycle", int'(wr_req), 1);
                end
            end
            if (wr_ack) begin
                wr_ack = 1'b0;
                wcnt = 0;
            end else if (wr_req) begin
                if (wcnt >= delay) begin
                    wr_ack = 1'b1;
                    compare_write();
                    if (rand_delay) delay = next_rand() % 4;
                end else begin
                    wcnt++;
                end
            end
            prev_wr = wr_req; prev_ack = wr_ack;
            prev_x = pix_x; prev_y = pix_y; prev_d = pix_data;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    // Scenario: clear, four differently patterned frames, mid-frame reset, one more frame
    initial begin
        set_grid(0);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        wait (frame_no >= 4);
        repeat (41) @(posedge clk);
        #1 rst_n = 1'b0;
        mid_reset = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        wait (frame_no >= 5);
        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule